// File: doc/BRIEF.md
# Power-Level Data Selector and Strobe

This block picks one of three power setpoints, each held as a three-digit BCD word, and presents it on a single 12-bit output. A downstream register captures that output. Three one-hot select lines come from a power-level latch and decide which setpoint is shown. If no line is active, the output reads zero. If more than one line is active, that is a fault: the output is forced to zero and an error flag is raised.

The block also makes the capture pulse for the downstream register. The register loads on the rising edge of the pulse. A pulse is raised in three cases:
- when an active-low step-start pulse ends;
- when an active-low level-change pulse ends;
- after a fixed delay following each rising edge of the setpoint counter clock.

The delay gives the counters time to settle before their value is captured. The default of 100 cycles matches about 100 µs at a 1 MHz system clock. All inputs are synchronous to the system clock.

Each pulse is one clock wide. Pulses are always separated by at least one low cycle, so that every request gives the downstream register a clean rising edge. The output word is frozen on the edge where a pulse rises, so the register never captures a word that is changing.

Top module: `power_level_selector`

## Requirements
- R1: Select lines `selHigh`, `selMed` and `selLow` route `highWord`, `medWord` and `lowWord` respectively. When exactly one line is high, `dataOut` shows that word one clock after the select and the word are sampled.
- R2: When no select line is high, `dataOut` is all zeros one clock later.
- R3: When two or more select lines are high, `dataOut` is all zeros and `selError` is 1 one clock later. Otherwise `selError` is 0.
- R4: When `startPulseN` is first sampled high after being sampled low, `strobe` is 1 for exactly one cycle, starting at that same clock edge. The falling edge of `startPulseN` produces no strobe.
- R5: `levelChangeN` behaves the same way: only the end of its low pulse produces a one-cycle strobe, at the edge where it is first sampled high.
- R6: A rising edge of `countClk`, sampled at edge k, raises `strobe` at edge k+DELAY_CYCLES. `strobe` stays low in every cycle before that. A falling edge of `countClk` produces no strobe.
- R7: A new `countClk` rising edge that arrives before a pending delayed strobe has fired restarts the delay. Only one strobe results, timed from the later edge.
- R8: `strobe` is never high in two consecutive cycles. Requests that fall in the same cycle merge into one pulse. A request that arrives while `strobe` is high is issued one cycle after `strobe` returns low.
- R9: At the clock edge where `strobe` rises, `dataOut` keeps its previous value. Pending word changes appear one edge later.
- R10: While `rst_n` is low, `dataOut` is zero and `strobe` and `selError` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| highWord | input | 12 | High-level setpoint, three BCD digits |
| medWord | input | 12 | Medium-level setpoint, three BCD digits |
| lowWord | input | 12 | Low-level setpoint, three BCD digits |
| selHigh | input | 1 | Selects `highWord` |
| selMed | input | 1 | Selects `medWord` |
| selLow | input | 1 | Selects `lowWord` |
| startPulseN | input | 1 | Active-low step-start pulse; its end requests a strobe |
| levelChangeN | input | 1 | Active-low level-change pulse; its end requests a strobe |
| countClk | input | 1 | Setpoint counter clock; each rising edge requests a delayed strobe |
| dataOut | output | 12 | Selected setpoint, or zero |
| strobe | output | 1 | One-cycle capture pulse for the downstream register |
| selError | output | 1 | More than one select line was active |

## Verification
The selector is swept over all eight select combinations for ten sets of distinct BCD words. This separates routing to the correct word from the all-zero cases, and it separates the no-select zero from the multi-select zero, which must also raise the error flag.

The strobe is exercised in several ways:
- each source alone, including the edges that must not trigger a strobe;
- a retriggered counter clock inside the delay window;
- two pulse ends landing in the same cycle, which must merge;
- two pulse ends in adjacent cycles, which must be split into two pulses.

A word change that arrives together with a strobe shows that the output holds at the strobe's rising edge.

// File: rtl/pwr_sel_pkg.sv
package pwr_sel_pkg;
  // Commands from the control path to the datapath.
  typedef struct packed {
    logic loadDelay;  // counter-clock rise seen: (re)start delay timer
    logic holdWord;   // strobe rises at this edge: keep dataOut steady
  } ctrl_strobes_t;
endpackage

// File: rtl/pwr_sel_datapath.sv
module pwr_sel_datapath
  import pwr_sel_pkg::*;
#(
  parameter int DIGITS       = 3,
  parameter int DIGIT_W      = 4,
  parameter int LEVELS       = 3,
  parameter int DELAY_CYCLES = 100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LEVELS*DIGITS*DIGIT_W-1:0] levelWords,
  input  logic [LEVELS-1:0]             selVec,
  input  ctrl_strobes_t                 ctrl,
  output logic [DIGITS*DIGIT_W-1:0]     dataOut,
  output logic                          selError,
  output logic                          delayDone
);
  localparam int WORD_W = DIGITS * DIGIT_W;
  localparam int CNT_W  = $clog2(DELAY_CYCLES + 1);

  logic [WORD_W-1:0] lane [LEVELS];
  logic [WORD_W-1:0] merged;
  logic              multiHot;
  logic [CNT_W-1:0]  delayCnt;

  // One gated lane per power level.
  for (genvar g = 0; g < LEVELS; g++) begin : g_lane
    assign lane[g] = selVec[g] ? levelWords[g*WORD_W +: WORD_W] : '0;
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < LEVELS; i++) merged = merged | lane[i];
    multiHot = ($countones(selVec) > 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataOut  <= '0;
      selError <= 1'b0;
    end else begin
      selError <= multiHot;
      if (!ctrl.holdWord) dataOut <= multiHot ? '0 : merged;
    end
  end

  // Settling delay for counter-clock strobes; a reload restarts the window.
  always_ff @(posedge clk) begin
    if (!rst_n)                 delayCnt <= '0;
    else if (ctrl.loadDelay)    delayCnt <= CNT_W'(DELAY_CYCLES);
    else if (delayCnt != '0)    delayCnt <= delayCnt - 1'b1;
  end

  assign delayDone = (delayCnt == CNT_W'(1));

  p_multi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(selVec) > 1) && !ctrl.holdWord |=> (dataOut == '0) && selError);

  p_single_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(selVec) <= 1) |=> !selError);

  p_none_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (selVec == '0) && !ctrl.holdWord |=> (dataOut == '0));
endmodule

// File: rtl/pwr_sel_control.sv
module pwr_sel_control
  import pwr_sel_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          startPulseN,
  input  logic          levelChangeN,
  input  logic          countClk,
  input  logic          delayDone,
  output logic          strobe,
  output ctrl_strobes_t ctrl
);
  logic prevStart, prevLevel, prevClk;
  logic startEnd, levelEnd, clkRise;
  logic pending, request, strobeNext;

  // Previous samples track the inputs even in reset, so no edge is invented.
  always_ff @(posedge clk) begin
    prevStart <= startPulseN;
    prevLevel <= levelChangeN;
    prevClk   <= countClk;
  end

  always_comb begin
    startEnd   = startPulseN  & ~prevStart;
    levelEnd   = levelChangeN & ~prevLevel;
    clkRise    = countClk     & ~prevClk;
    request    = startEnd | levelEnd | delayDone | pending;
    strobeNext = request & ~strobe;
    ctrl.loadDelay = clkRise;
    ctrl.holdWord  = strobeNext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe  <= 1'b0;
      pending <= 1'b0;
    end else begin
      strobe  <= strobeNext;
      pending <= request & strobe;
    end
  end

  p_strobe_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  p_start_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(startPulseN) && !strobe |=> strobe);

  p_level_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(levelChangeN) && !strobe |=> strobe);
endmodule

// File: rtl/power_level_selector.sv
module power_level_selector
  import pwr_sel_pkg::*;
#(
  parameter int DIGITS       = 3,
  parameter int DIGIT_W      = 4,
  parameter int DELAY_CYCLES = 100
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DIGITS*DIGIT_W-1:0] highWord,
  input  logic [DIGITS*DIGIT_W-1:0] medWord,
  input  logic [DIGITS*DIGIT_W-1:0] lowWord,
  input  logic                      selHigh,
  input  logic                      selMed,
  input  logic                      selLow,
  input  logic                      startPulseN,
  input  logic                      levelChangeN,
  input  logic                      countClk,
  output logic [DIGITS*DIGIT_W-1:0] dataOut,
  output logic                      strobe,
  output logic                      selError
);
  localparam int LEVELS = 3;

  ctrl_strobes_t ctrl;
  logic          delayDone;

  pwr_sel_control u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .startPulseN  (startPulseN),
    .levelChangeN (levelChangeN),
    .countClk     (countClk),
    .delayDone    (delayDone),
    .strobe       (strobe),
    .ctrl         (ctrl)
  );

  pwr_sel_datapath #(
    .DIGITS       (DIGITS),
    .DIGIT_W      (DIGIT_W),
    .LEVELS       (LEVELS),
    .DELAY_CYCLES (DELAY_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .levelWords ({highWord, medWord, lowWord}),
    .selVec     ({selHigh, selMed, selLow}),
    .ctrl       (ctrl),
    .dataOut    (dataOut),
    .selError   (selError),
    .delayDone  (delayDone)
  );

  p_hold_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $stable(dataOut));
endmodule

// File: tb/power_level_selector_tb_top.sv
module power_level_selector_tb_top;
  localparam int D = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] highWord, medWord, lowWord;
  logic        selHigh, selMed, selLow;
  logic        startPulseN, levelChangeN, countClk;
  logic [11:0] dataOut;
  logic        strobe, selError;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  power_level_selector #(.DELAY_CYCLES(D)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .highWord(highWord), .medWord(medWord), .lowWord(lowWord),
    .selHigh(selHigh), .selMed(selMed), .selLow(selLow),
    .startPulseN(startPulseN), .levelChangeN(levelChangeN), .countClk(countClk),
    .dataOut(dataOut), .strobe(strobe), .selError(selError)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  function automatic logic [11:0] bcd(int n);
    return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; startPulseN = 1; levelChangeN = 1; countClk = 0;
    selHigh = 0; selMed = 0; selLow = 0;
    highWord = 12'h123; medWord = 12'h456; lowWord = 12'h789;
    #2; tick(3);
    chk("R10 dataOut", dataOut, 0);
    chk("R10 strobe", strobe, 0);
    chk("R10 selError", selError, 0);
    rst_n = 1; tick(2);

    // Selector sweep.
    for (int p = 0; p < 10; p++) begin
      highWord = bcd((p * 137 + 5) % 1000);
      medWord  = bcd((p * 291 + 42) % 1000);
      lowWord  = bcd((p * 53 + 700) % 1000);
      for (int s = 0; s < 8; s++) begin
        logic [11:0] exp;
        int ones;
        {selHigh, selMed, selLow} = 3'(s);
        ones = $countones(3'(s));
        exp = (ones != 1) ? 12'h000 : (s == 4) ? highWord : (s == 2) ? medWord : lowWord;
        tick(1);
        if (ones == 1)      chk("R1 dataOut", dataOut, exp);
        else if (ones == 0) chk("R2 dataOut", dataOut, exp);
        else                chk("R3 dataOut", dataOut, exp);
        chk("R3 selError", selError, (ones > 1) ? 1 : 0);
        chk("R4 no idle strobe", strobe, 0);
      end
    end
    selHigh = 0; selMed = 0; selLow = 0; tick(1);

    // R4: step-start end.
    startPulseN = 0; tick(1); chk("R4 fall no strobe", strobe, 0);
    tick(3); chk("R4 low no strobe", strobe, 0);
    startPulseN = 1; tick(1); chk("R4 end strobe", strobe, 1);
    tick(1); chk("R4 one cycle", strobe, 0);

    // R5: level-change end.
    levelChangeN = 0; tick(1); chk("R5 fall no strobe", strobe, 0);
    tick(2);
    levelChangeN = 1; tick(1); chk("R5 end strobe", strobe, 1);
    tick(1); chk("R5 one cycle", strobe, 0);

    // R6: delayed counter-clock strobe.
    countClk = 1;
    for (int j = 1; j <= D; j++) begin
      tick(1);
      if (j == 1) countClk = 0;
      chk("R6 before delay", strobe, 0);
    end
    tick(1); chk("R6 delayed strobe", strobe, 1);
    tick(1); chk("R6 one cycle", strobe, 0);
    tick(D + 2); chk("R6 no extra", strobe, 0);

    // R7: retrigger inside the window.
    countClk = 1; tick(1);
    countClk = 0; tick(1);
    countClk = 1; tick(1);
    countClk = 0;
    for (int j = 1; j < D; j++) begin
      tick(1); chk("R7 no early strobe", strobe, 0);
    end
    tick(1); chk("R7 strobe from later edge", strobe, 1);
    tick(1); chk("R7 one cycle", strobe, 0);
    tick(D + 2); chk("R7 single strobe", strobe, 0);

    // R8: coincident requests merge.
    startPulseN = 0; levelChangeN = 0; tick(2);
    startPulseN = 1; levelChangeN = 1; tick(1); chk("R8 merged strobe", strobe, 1);
    tick(1); chk("R8 merged low", strobe, 0);
    tick(1); chk("R8 merged single", strobe, 0);

    // R8: adjacent requests split.
    startPulseN = 0; levelChangeN = 0; tick(2);
    startPulseN = 1; tick(1); chk("R8 first strobe", strobe, 1);
    levelChangeN = 1; tick(1); chk("R8 gap", strobe, 0);
    tick(1); chk("R8 deferred strobe", strobe, 1);
    tick(1); chk("R8 deferred one cycle", strobe, 0);

    // R9: word frozen at strobe rise.
    selHigh = 1; highWord = 12'h321; tick(2);
    chk("R1 setup word", dataOut, 12'h321);
    startPulseN = 0; tick(2);
    highWord = 12'h654; startPulseN = 1; tick(1);
    chk("R9 strobe", strobe, 1);
    chk("R9 held word", dataOut, 12'h321);
    tick(1); chk("R9 new word after", dataOut, 12'h654);

    finish_run();
  end
endmodule